// File: doc/BRIEF.md
# Configuration Clock Burst Generator

This block produces a counted run of clock pulses on a dedicated configuration clock pin. A programmable-logic configuration sink needs such runs to flush errors or to prepare before data streaming starts. Software writes a pulse count into a count register over a simple 32-bit register bus. The block then drives that many pulses at half the bus clock rate and raises a completion flag in a status register. The flag stays set until software clears it by writing a one to it.

Software clears the flag, writes the count, polls the flag and then clears it again. A `busy` output marks the span of the burst for neighbouring logic. A count of zero completes at once. Bursts of up to 2047 pulses finish in about 4094 bus cycles.

Top module: `cfgclk_burst_gen`

## Requirements
- R1: After reset `cfg_clk` and `busy` are low, and both the count register and the status register read as zero.
- R2: A write to byte offset 0x08 while idle, with a nonzero count in data bits [CNT_W-1:0], produces exactly that many rising edges on `cfg_clk`.
- R3: During a burst `cfg_clk` alternates one bus cycle high and one bus cycle low, starting high in the cycle after the accepted write. Whenever `busy` is low, `cfg_clk` is low.
- R4: `busy` rises in the cycle after an accepted nonzero write. It stays high for 2N-1 cycles and falls on the same edge as the last falling edge of `cfg_clk`.
- R5: Status bit 0 (byte offset 0x0c) sets on the edge where the burst ends and then stays set.
- R6: Writing 1 to status bit 0 clears it, and writes with bit 0 at zero leave it unchanged. If a clear arrives on the edge where a burst ends, the flag ends up set.
- R7: A write to the count register while `busy` is high is ignored. The running burst keeps its length and the count readback keeps its value.
- R8: A count of zero sets the done flag on the write edge, produces no pulses and leaves `busy` low.
- R9: The count field is CNT_W = 11 bits wide and higher data bits are ignored. Offset 0x08 reads back the last accepted count, and a 2047-pulse burst completes.
- R10: Reads of any other offset, or of an offset that is not word-aligned, return zero. Writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| cfg_clk | output | 1 | Configuration clock pulses toward the sink |
| busy | output | 1 | High while a burst is in progress |

## Verification
If the remaining-pulse counter is off by one, the number of `cfg_clk` rising edges differs from the count written. The `busy` window also moves by two cycles, and both show at the ports by the end of that same burst. If the phase bit is held or toggles twice in a row, a high or low level lasts two cycles, which is visible one cycle after it happens. If the done flag mishandles set against clear, the status readback differs in the cycle after the colliding edge. A busy gate that lets a second count through shows as an extra pulse count and a changed count readback as soon as that burst ends.

// File: rtl/cgb_pkg.sv
package cgb_pkg;
  // word indices of the two registers (byte offsets 0x08 and 0x0c)
  localparam int unsigned CGB_COUNT_WORD = 2;
  localparam int unsigned CGB_STAT_WORD  = 3;

  function automatic bit cgb_aligned(input logic [31:0] byte_addr);
    return byte_addr[1:0] == 2'b00;
  endfunction

  function automatic int unsigned cgb_word(input logic [31:0] byte_addr);
    return int'(byte_addr >> 2);
  endfunction

  // cycles the busy window lasts for a count n
  function automatic int unsigned cgb_busy_cycles(input int unsigned n);
    return (n == 0) ? 0 : (2 * n - 1);
  endfunction
endpackage

// File: rtl/cgb_regif.sv
module cgb_regif #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              start_accept,
  input  logic              done,
  output logic              count_wr,
  output logic              clear_req,
  output logic [CNT_W-1:0]  count_field,
  output logic [CNT_W-1:0]  count_q,
  output logic [DATA_W-1:0] bus_rdata
);
  import cgb_pkg::*;

  logic [31:0] addr32;
  logic        sel_count;
  logic        sel_stat;
  logic        wdata_unused;

  assign addr32       = 32'(bus_addr);
  assign sel_count    = cgb_aligned(addr32) && (cgb_word(addr32) == CGB_COUNT_WORD);
  assign sel_stat     = cgb_aligned(addr32) && (cgb_word(addr32) == CGB_STAT_WORD);
  assign count_wr     = bus_wr && sel_count;
  assign clear_req    = bus_wr && sel_stat && bus_wdata[0];
  assign count_field  = bus_wdata[CNT_W-1:0];
  assign wdata_unused = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else if (start_accept) count_q <= count_field;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_count) bus_rdata = DATA_W'(count_q);
    else if (sel_stat) bus_rdata = DATA_W'(done);
  end
endmodule

// File: rtl/cgb_pulse_engine.sv
module cgb_pulse_engine #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [CNT_W-1:0] start_count,
  output logic             busy,
  output logic             dclk,
  output logic             start_accept,
  output logic             burst_end
);
  logic [CNT_W-1:0] rem_q;
  logic             last_pulse;

  assign start_accept = start_req && !busy;
  assign last_pulse   = busy && dclk && (rem_q == CNT_W'(1));
  assign burst_end    = (start_accept && (start_count == '0)) || last_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      dclk  <= 1'b0;
      rem_q <= '0;
    end else if (!busy) begin
      if (start_req && (start_count != '0)) begin
        busy  <= 1'b1;
        dclk  <= 1'b1;
        rem_q <= start_count;
      end
    end else if (dclk) begin
      dclk <= 1'b0;
      if (last_pulse) begin
        busy  <= 1'b0;
        rem_q <= '0;
      end else begin
        rem_q <= rem_q - CNT_W'(1);
      end
    end else begin
      dclk <= 1'b1;
    end
  end
endmodule

// File: rtl/cgb_done_flag.sv
module cgb_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clear_evt,
  output logic done
);
  // a set on the same edge as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else if (set_evt) done <= 1'b1;
    else if (clear_evt) done <= 1'b0;
  end
endmodule

// File: rtl/cfgclk_burst_gen.sv
module cfgclk_burst_gen #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cfg_clk,
  output logic              busy
);
  logic             count_wr;
  logic             clear_req;
  logic [CNT_W-1:0] count_field;
  logic [CNT_W-1:0] count_q;
  logic             start_accept;
  logic             burst_end;
  logic             done;
  logic             count_is_zero;

  assign count_is_zero = (count_field == '0);

  cgb_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regif_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .start_accept(start_accept), .done(done),
    .count_wr(count_wr), .clear_req(clear_req), .count_field(count_field),
    .count_q(count_q), .bus_rdata(bus_rdata)
  );

  cgb_pulse_engine #(.CNT_W(CNT_W)) engine_i (
    .clk(clk), .rst_n(rst_n), .start_req(count_wr), .start_count(count_field),
    .busy(busy), .dclk(cfg_clk), .start_accept(start_accept), .burst_end(burst_end)
  );

  cgb_done_flag flag_i (
    .clk(clk), .rst_n(rst_n), .set_evt(burst_end), .clear_evt(clear_req), .done(done)
  );
endmodule

// File: rtl/cfgclk_burst_gen_chk.sv
module cfgclk_burst_gen_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             cfg_clk,
  input logic             done,
  input logic             start_accept,
  input logic             count_wr,
  input logic             count_is_zero,
  input logic             burst_end,
  input logic             clear_req,
  input logic [CNT_W-1:0] count_q
);
  assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cfg_clk);
  assert_high_then_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_clk) |=> !cfg_clk);
  assert_low_then_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_clk) |=> (busy && cfg_clk));
  assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_accept && !count_is_zero) |=> (busy && cfg_clk));
  assert_busy_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cfg_clk) && !cfg_clk));
  assert_done_on_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> done);
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear_req) |=> done);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_req && !burst_end) |=> !done);
  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_wr && busy) |=> $stable(count_q));
  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_accept && count_is_zero) |=> (!busy && !cfg_clk && done));
endmodule

bind cfgclk_burst_gen cfgclk_burst_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cfg_clk(cfg_clk), .done(done),
  .start_accept(start_accept), .count_wr(count_wr), .count_is_zero(count_is_zero),
  .burst_end(burst_end), .clear_req(clear_req), .count_q(count_q)
);

// File: tb/cfgclk_burst_gen_tb_top.sv
`timescale 1ns/1ps
module cfgclk_burst_gen_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 11;
  localparam logic [ADDR_W-1:0] A_CNT  = 8'h08;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h0c;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              cfg_clk;
  logic              busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rises, busy_cyc, high_cyc, idle_bad;

  always #2 clk = ~clk;

  cfgclk_burst_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_clk(cfg_clk), .busy(busy)
  );

  always @(posedge cfg_clk) rises++;
  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (busy && cfg_clk) high_cyc++;
    if (!busy && cfg_clk) idle_bad++;
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected finish earlier", cyc);
      report();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rises = 0; busy_cyc = 0; high_cyc = 0; idle_bad = 0;
  endtask

  // one write, sampled on the next rising edge; returns just after that edge
  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 6000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_busy(input int n);
    return (n > 0) ? n + n - 1 : 0;
  endfunction

  task automatic t_reset();
    logic [DATA_W-1:0] r;
    check(!cfg_clk && !busy, "R1 idle pins after reset", {cfg_clk, busy}, 0);
    bus_read(A_STAT, r);
    check(r == 0, "R1 status after reset", r, 0);
    bus_read(A_CNT, r);
    check(r == 0, "R1 count after reset", r, 0);
  endtask

  task automatic t_burst(input logic [DATA_W-1:0] wval);
    logic [DATA_W-1:0] r;
    int n;
    n = int'(wval & 32'h7ff);
    bus_write(A_STAT, 32'h1);
    clear_mon();
    bus_write(A_CNT, wval);
    check(busy == (n != 0), "R4 busy right after write", busy, n != 0);
    wait_idle();
    check(rises == n, "R2 pulse count", rises, n);
    check(high_cyc == n, "R3 high cycles", high_cyc, n);
    check(idle_bad == 0, "R3 clock low while idle", idle_bad, 0);
    check(busy_cyc == exp_busy(n), "R4 busy window", busy_cyc, exp_busy(n));
    bus_read(A_STAT, r);
    check(r == 1, "R5 done after burst", r, 1);
    bus_read(A_CNT, r);
    check(r == n, "R9 count readback", r, n);
  endtask

  task automatic t_zero();
    logic [DATA_W-1:0] r;
    bus_write(A_STAT, 32'h1);
    clear_mon();
    bus_write(A_CNT, 32'h0);
    check(!busy, "R8 busy stays low", busy, 0);
    bus_read(A_STAT, r);
    check(r == 1, "R8 done at once", r, 1);
    repeat (4) @(negedge clk);
    check(rises == 0 && busy_cyc == 0, "R8 no pulses", rises, 0);
  endtask

  task automatic t_clear();
    logic [DATA_W-1:0] r;
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, r);
    check(r == 1, "R6 write of zero keeps done", r, 1);
    bus_write(A_STAT, 32'hFFFF_FFFE);
    bus_read(A_STAT, r);
    check(r == 1, "R6 bit0 clear keeps done", r, 1);
    bus_write(A_STAT, 32'h1);
    bus_read(A_STAT, r);
    check(r == 0, "R6 write one clears done", r, 0);
  endtask

  task automatic t_ignore();
    logic [DATA_W-1:0] r;
    bus_write(A_STAT, 32'h1);
    clear_mon();
    bus_write(A_CNT, 32'd10);
    repeat (3) @(posedge clk);
    bus_write(A_CNT, 32'd500);
    wait_idle();
    check(rises == 10, "R7 burst length kept", rises, 10);
    bus_read(A_CNT, r);
    check(r == 10, "R7 count readback kept", r, 10);
  endtask

  task automatic t_set_wins();
    logic [DATA_W-1:0] r;
    bus_write(A_STAT, 32'h1);
    clear_mon();
    bus_write(A_CNT, 32'd2);          // edge E0, burst ends at E3
    bus_write(8'h10, 32'd7);          // edge E1, unmapped
    @(posedge clk);                   // E2 passes
    bus_write(A_STAT, 32'h1);         // edge E3 collides with burst end
    bus_read(A_STAT, r);
    check(r == 1, "R6 set wins over clear", r, 1);
    check(rises == 2, "R10 unmapped write no effect", rises, 2);
    bus_read(A_CNT, r);
    check(r == 2, "R10 count untouched", r, 2);
  endtask

  task automatic t_unmapped();
    logic [DATA_W-1:0] r;
    bus_read(8'h00, r);
    check(r == 0, "R10 read offset 0x00", r, 0);
    bus_read(8'h04, r);
    check(r == 0, "R10 read offset 0x04", r, 0);
    bus_read(8'h09, r);
    check(r == 0, "R10 read misaligned 0x09", r, 0);
    bus_read(8'h10, r);
    check(r == 0, "R10 read offset 0x10", r, 0);
    bus_write(8'h0d, 32'h1);
    bus_read(A_STAT, r);
    check(r == 1, "R10 misaligned clear ignored", r, 1);
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_burst(32'd1);
    t_burst(32'd3);
    t_burst(32'd256);
    t_zero();
    t_clear();
    t_burst(32'hFFFF_F805);   // R9 upper bits dropped, 5 pulses
    t_ignore();
    t_set_wins();
    t_unmapped();
    t_burst(32'h7FF);         // R9 longest burst
    report();
    $finish;
  end
endmodule